// File: doc/BRIEF.md
# Burst Packet Pattern Generator

This block produces the transmit byte stream for a burst-mode bit error tester. It imitates several upstream terminals that share one channel by taking turns. Every clock it emits one byte of a framed burst. Each burst is built from the same fields in the same order. A silent guard gap comes first, then a training pattern of alternating bits and a fixed synchronisation word. After that come a pseudo-random payload and, if enabled, a long run of identical bits that stresses the receiver's clock recovery.

The combined stream is also split into one byte lane per terminal. Bursts rotate across the lanes, starting at lane 0. Only the lane that owns the current burst carries the data, and every other lane reads zero. Framing strobes mark the first byte of a burst, the last byte of a burst and the payload bytes.

The configuration inputs are the field lengths, a payload length for each lane, the constant-run length and level, and the pattern choice. They are captured once per burst, so the configuration can be rewritten at any time without breaking a burst that is already under way.

Top module: `burst_pattern_gen`

## Requirements
- R1: All outputs are registered. While `rst` is high, every output reads zero after each clock edge. The first clock edge with `rst` low presents the first guard byte of a burst on lane 0.
- R2: A burst opens with max(1, `cfg_guard_bytes`) bytes of 0x00. `tx_sop` is high on the first guard byte only.
- R3: After the guard come `cfg_pre_bytes` bytes of 0xAA. A setting of zero leaves out this field.
- R4: After the training bytes come exactly three bytes, 0xAB, 0x59 and 0x83. These are the nibble 1010 followed by the 20-bit word 0xB5983, sent MSB first.
- R5: The payload length in bytes is the setting for the burst's lane. The lane-k length sits at bits [16k+15:16k] of `cfg_pay_bytes`, and zero leaves out the payload. `tx_payload` is high on exactly the payload bytes.
- R6: Payload bits come from a 31-bit shift register s that is set to all ones by reset. For each bit, nb = s[a] ^ s[b] and s becomes {s[29:0], nb}. The bits fill a byte MSB first, eight bits per byte. `cfg_pattern` 0 uses a=6, b=5 (x^7+x^6+1). A value of 1 uses a=22, b=17 (x^23+x^18+1). A value of 2 or 3 uses a=30, b=27 (x^31+x^28+1).
- R7: The shift register advances only on payload bytes. If the pattern stays the same, the payload of a burst continues the sequence exactly where the previous burst's payload stopped.
- R8: After the payload come `cfg_run_bytes` bytes, each holding eight copies of `cfg_run_level`. Zero leaves out the run.
- R9: Bursts rotate through lanes 0, 1, … and wrap back to 0. `tx_lane` gives the owner of the current byte. Lane k appears at `lane_byte[8k+7:8k]` and carries `tx_byte` while it owns the burst; at all other times it reads 0x00.
- R10: `tx_eop` is high on the last byte of each burst. The guard byte of the next burst follows on the very next cycle.
- R11: All settings are taken from the inputs as they stand at the clock edge one cycle before the edge that presents a burst's first guard byte. Changes at any later time have no effect until the next burst.
- R12: If the pattern captured for a burst differs from the one captured for the previous burst, the shift register restarts from all ones for that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_guard_bytes | input | GUARD_W | Guard length in bytes (0 treated as 1) |
| cfg_pre_bytes | input | PRE_W | Training pattern length in bytes |
| cfg_pay_bytes | input | LANES*LEN_W | Payload length for each lane, lane 0 in the low bits |
| cfg_run_bytes | input | LEN_W | Constant-run length in bytes |
| cfg_run_level | input | 1 | Bit value of the constant run |
| cfg_pattern | input | 2 | Pseudo-random polynomial select |
| tx_byte | output | 8 | Combined stream byte |
| lane_byte | output | LANES*8 | Per-lane byte streams |
| tx_lane | output | LANE_W | Lane that owns the current byte |
| tx_sop | output | 1 | First byte of a burst |
| tx_eop | output | 1 | Last byte of a burst |
| tx_payload | output | 1 | Current byte is payload |

## Verification
Each output byte appears one clock edge after the sequencer state that produced it. A burst's configuration is sampled one edge earlier than the edge that shows its first guard byte. The bench reads the outputs at the falling edge. It builds each expected burst from the configuration it drove two falling edges before that burst's first guard byte is read, and it keeps a two-deep history of its own drives for this purpose. Reset is handled the same way: the bench treats a falling edge as a reset cycle when reset was driven on the falling edge just before it. Random configuration changes land at any byte of a burst, so a design that picked up a setting early or late would show a mismatch at a known byte.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

    localparam int          PRBS_W      = 31;
    localparam logic [7:0]  TRAIN_BYTE  = 8'hAA;
    localparam int          SYNC_BYTES  = 3;
    // trailing training nibble followed by the 20-bit sync word
    localparam logic [23:0] SYNC_WORD   = {4'b1010, 20'hB5983};

    typedef enum logic [2:0] {
        FLD_GUARD,
        FLD_TRAIN,
        FLD_SYNC,
        FLD_PAY,
        FLD_RUN
    } field_e;

    typedef struct packed {
        logic sop;
        logic eop;
        logic payload;
    } frame_info_t;

    typedef struct packed {
        logic [PRBS_W-1:0] state;
        logic [7:0]        data;
    } prbs_res_t;

    // field order with empty fields skipped; guard is never empty
    function automatic field_e next_field(field_e cur, logic has_train,
                                          logic has_pay, logic has_run);
        field_e nf;
        unique case (cur)
            FLD_GUARD: nf = has_train ? FLD_TRAIN : FLD_SYNC;
            FLD_TRAIN: nf = FLD_SYNC;
            FLD_SYNC:  nf = has_pay ? FLD_PAY : (has_run ? FLD_RUN : FLD_GUARD);
            FLD_PAY:   nf = has_run ? FLD_RUN : FLD_GUARD;
            default:   nf = FLD_GUARD;
        endcase
        return nf;
    endfunction

    function automatic logic [7:0] sync_byte(logic [1:0] idx);
        logic [7:0] b;
        unique case (idx)
            2'd0:    b = SYNC_WORD[23:16];
            2'd1:    b = SYNC_WORD[15:8];
            default: b = SYNC_WORD[7:0];
        endcase
        return b;
    endfunction

    // eight serial steps of the selected Fibonacci register, first bit in MSB
    function automatic prbs_res_t prbs_step(logic [PRBS_W-1:0] s, logic [1:0] sel);
        prbs_res_t          r;
        logic               nb;
        logic [PRBS_W-1:0]  st;
        st     = s;
        r.data = '0;
        for (int i = 0; i < 8; i++) begin
            unique case (sel)
                2'd0:    nb = st[6]  ^ st[5];
                2'd1:    nb = st[22] ^ st[17];
                default: nb = st[30] ^ st[27];
            endcase
            st          = {st[PRBS_W-2:0], nb};
            r.data[7-i] = nb;
        end
        r.state = st;
        return r;
    endfunction

    // true when the bits used by the selected order are not all zero
    function automatic logic prbs_alive(logic [PRBS_W-1:0] s, logic [1:0] sel);
        logic ok;
        unique case (sel)
            2'd0:    ok = |s[6:0];
            2'd1:    ok = |s[22:0];
            default: ok = |s[30:0];
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bpg_prbs.sv
module bpg_prbs
    import bpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    input  logic       reseed,
    input  logic [1:0] sel,
    output logic [7:0] data
);

    logic [PRBS_W-1:0] state_q;
    prbs_res_t         step;

    assign step = prbs_step(state_q, sel);
    assign data = step.data;

    always_ff @(posedge clk) begin
        if (rst || reseed) begin
            state_q <= '1;
        end else if (advance) begin
            state_q <= step.state;
        end
    end

    // R6: the register never collapses into the all-zero lock state
    p_seed_alive_r6: assert property (@(posedge clk) disable iff (rst)
        prbs_alive(state_q, sel));

    // R7: no payload byte and no restart means the sequence stands still
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (!advance && !reseed) |=> $stable(state_q));

endmodule

// File: rtl/bpg_framer.sv
module bpg_framer
    import bpg_pkg::*;
#(
    parameter int GUARD_W = 8,
    parameter int PRE_W   = 8,
    parameter int LEN_W   = 16,
    parameter int LANES   = 2,
    parameter int LANE_W  = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [GUARD_W-1:0]     cfg_guard_bytes,
    input  logic [PRE_W-1:0]       cfg_pre_bytes,
    input  logic [LANES*LEN_W-1:0] cfg_pay_bytes,
    input  logic [LEN_W-1:0]       cfg_run_bytes,
    input  logic                   cfg_run_level,
    input  logic [1:0]             cfg_pattern,
    output field_e                 fld,
    output logic [1:0]             fld_idx,
    output frame_info_t            info,
    output logic [LANE_W-1:0]      lane,
    output logic                   run_level,
    output logic [1:0]             pattern,
    output logic                   prbs_adv,
    output logic                   prbs_reseed
);

    localparam int GP_W  = (GUARD_W > PRE_W) ? GUARD_W : PRE_W;
    localparam int CNT_W = (LEN_W > GP_W) ? LEN_W : GP_W;

    // per-burst captured settings
    logic [GUARD_W-1:0] g_q;
    logic [PRE_W-1:0]   p_q;
    logic [LEN_W-1:0]   pay_q [LANES];
    logic [LEN_W-1:0]   r_q;
    logic               lvl_q;
    logic [1:0]         pat_q;

    field_e             fld_q;
    logic [CNT_W-1:0]   idx_q;
    logic [LANE_W-1:0]  lane_q;

    logic [LEN_W-1:0]   pay_cur;
    logic [CNT_W-1:0]   fld_len;
    logic               last_in_field;
    logic               pkt_end;
    field_e             fld_nxt;
    logic [LANE_W-1:0]  lane_nxt;

    assign pay_cur = pay_q[lane_q];

    always_comb begin
        unique case (fld_q)
            FLD_GUARD: fld_len = (g_q == '0) ? CNT_W'(1) : CNT_W'(g_q);
            FLD_TRAIN: fld_len = CNT_W'(p_q);
            FLD_SYNC:  fld_len = CNT_W'(SYNC_BYTES);
            FLD_PAY:   fld_len = CNT_W'(pay_cur);
            default:   fld_len = CNT_W'(r_q);
        endcase
    end

    assign last_in_field = (idx_q == fld_len - CNT_W'(1));
    assign fld_nxt       = next_field(fld_q, p_q != '0, pay_cur != '0, r_q != '0);
    assign pkt_end       = last_in_field && (fld_nxt == FLD_GUARD);
    assign lane_nxt      = (lane_q == LANE_W'(LANES - 1)) ? '0 : lane_q + LANE_W'(1);

    // sequencer: field, byte index within the field, owning lane
    always_ff @(posedge clk) begin
        if (rst) begin
            fld_q  <= FLD_GUARD;
            idx_q  <= '0;
            lane_q <= '0;
        end else if (last_in_field) begin
            fld_q <= fld_nxt;
            idx_q <= '0;
            if (pkt_end) begin
                lane_q <= lane_nxt;
            end
        end else begin
            idx_q <= idx_q + CNT_W'(1);
        end
    end

    // settings are taken only on the edge that opens a burst
    always_ff @(posedge clk) begin
        if (rst || pkt_end) begin
            g_q   <= cfg_guard_bytes;
            p_q   <= cfg_pre_bytes;
            r_q   <= cfg_run_bytes;
            lvl_q <= cfg_run_level;
            pat_q <= cfg_pattern;
            for (int i = 0; i < LANES; i++) begin
                pay_q[i] <= cfg_pay_bytes[i*LEN_W +: LEN_W];
            end
        end
    end

    assign fld          = fld_q;
    assign fld_idx      = idx_q[1:0];
    assign info.sop     = (fld_q == FLD_GUARD) && (idx_q == '0);
    assign info.eop     = pkt_end;
    assign info.payload = (fld_q == FLD_PAY);
    assign lane         = lane_q;
    assign run_level    = lvl_q;
    assign pattern      = pat_q;
    assign prbs_adv     = (fld_q == FLD_PAY);
    assign prbs_reseed  = pkt_end && (cfg_pattern != pat_q);

    // R10: a burst ending is followed at once by a fresh guard field
    p_restart_guard_r10: assert property (@(posedge clk) disable iff (rst)
        pkt_end |=> (fld_q == FLD_GUARD) && (idx_q == '0));

    // R4: the training pattern is always followed by the sync word
    p_sync_after_train_r4: assert property (@(posedge clk) disable iff (rst)
        (fld_q == FLD_TRAIN && last_in_field) |=> (fld_q == FLD_SYNC));

    // R4: sync field never runs past its three bytes
    p_sync_span_r4: assert property (@(posedge clk) disable iff (rst)
        (fld_q == FLD_SYNC) |-> (idx_q < CNT_W'(SYNC_BYTES)));

    // R9: ownership changes only between bursts
    p_lane_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !pkt_end |=> $stable(lane_q));

    // R11: captured settings stay put inside a burst
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !pkt_end |=> ($stable(g_q) && $stable(p_q) && $stable(r_q)
                      && $stable(lvl_q) && $stable(pat_q)));

endmodule

// File: rtl/bpg_lane_split.sv
module bpg_lane_split
    import bpg_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [7:0]             byte_in,
    input  frame_info_t            info_in,
    input  logic [LANE_W-1:0]      lane_in,
    output logic [7:0]             tx_byte,
    output logic [LANES*8-1:0]     lane_byte,
    output logic [LANE_W-1:0]      tx_lane,
    output frame_info_t            info_out
);

    logic [LANES-1:0][7:0] lane_q;
    logic [LANES-1:0]      busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_byte  <= '0;
            tx_lane  <= '0;
            info_out <= '0;
        end else begin
            tx_byte  <= byte_in;
            tx_lane  <= lane_in;
            info_out <= info_in;
        end
    end

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[gi] <= '0;
            end else begin
                lane_q[gi] <= (lane_in == LANE_W'(gi)) ? byte_in : 8'h00;
            end
        end
        assign busy[gi]                = |lane_q[gi];
        assign lane_byte[gi*8 +: 8]    = lane_q[gi];
    end

    // R9: at most one lane carries a nonzero byte at a time
    p_single_lane_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(busy));

endmodule

// File: rtl/burst_pattern_gen.sv
module burst_pattern_gen
    import bpg_pkg::*;
#(
    parameter int GUARD_W = 8,
    parameter int PRE_W   = 8,
    parameter int LEN_W   = 16,
    parameter int LANES   = 2,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [GUARD_W-1:0]     cfg_guard_bytes,
    input  logic [PRE_W-1:0]       cfg_pre_bytes,
    input  logic [LANES*LEN_W-1:0] cfg_pay_bytes,
    input  logic [LEN_W-1:0]       cfg_run_bytes,
    input  logic                   cfg_run_level,
    input  logic [1:0]             cfg_pattern,
    output logic [7:0]             tx_byte,
    output logic [LANES*8-1:0]     lane_byte,
    output logic [LANE_W-1:0]      tx_lane,
    output logic                   tx_sop,
    output logic                   tx_eop,
    output logic                   tx_payload
);

    field_e            fld;
    logic [1:0]        fld_idx;
    frame_info_t       info;
    frame_info_t       info_r;
    logic [LANE_W-1:0] lane;
    logic              run_level;
    logic [1:0]        pattern;
    logic              prbs_adv;
    logic              prbs_reseed;
    logic [7:0]        prbs_data;
    logic [7:0]        cur_byte;

    bpg_framer #(
        .GUARD_W (GUARD_W),
        .PRE_W   (PRE_W),
        .LEN_W   (LEN_W),
        .LANES   (LANES),
        .LANE_W  (LANE_W)
    ) u_framer (
        .clk             (clk),
        .rst             (rst),
        .cfg_guard_bytes (cfg_guard_bytes),
        .cfg_pre_bytes   (cfg_pre_bytes),
        .cfg_pay_bytes   (cfg_pay_bytes),
        .cfg_run_bytes   (cfg_run_bytes),
        .cfg_run_level   (cfg_run_level),
        .cfg_pattern     (cfg_pattern),
        .fld             (fld),
        .fld_idx         (fld_idx),
        .info            (info),
        .lane            (lane),
        .run_level       (run_level),
        .pattern         (pattern),
        .prbs_adv        (prbs_adv),
        .prbs_reseed     (prbs_reseed)
    );

    bpg_prbs u_prbs (
        .clk     (clk),
        .rst     (rst),
        .advance (prbs_adv),
        .reseed  (prbs_reseed),
        .sel     (pattern),
        .data    (prbs_data)
    );

    always_comb begin
        unique case (fld)
            FLD_GUARD: cur_byte = 8'h00;
            FLD_TRAIN: cur_byte = TRAIN_BYTE;
            FLD_SYNC:  cur_byte = sync_byte(fld_idx);
            FLD_PAY:   cur_byte = prbs_data;
            default:   cur_byte = {8{run_level}};
        endcase
    end

    bpg_lane_split #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_split (
        .clk       (clk),
        .rst       (rst),
        .byte_in   (cur_byte),
        .info_in   (info),
        .lane_in   (lane),
        .tx_byte   (tx_byte),
        .lane_byte (lane_byte),
        .tx_lane   (tx_lane),
        .info_out  (info_r)
    );

    assign tx_sop     = info_r.sop;
    assign tx_eop     = info_r.eop;
    assign tx_payload = info_r.payload;

    // R2: guard bytes on the output are silent
    p_guard_silent_r2: assert property (@(posedge clk) disable iff (rst)
        tx_sop |-> (tx_byte == 8'h00));

    // R5: payload flag and burst opening never coincide
    p_pay_not_sop_r5: assert property (@(posedge clk) disable iff (rst)
        tx_payload |-> !tx_sop);

endmodule

// File: tb/test_burst_pattern_gen.sv
module test_burst_pattern_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  c_guard = 8'd4;
    logic [7:0]  c_pre   = 8'd5;
    logic [15:0] c_pay0  = 16'd12;
    logic [15:0] c_pay1  = 16'd20;
    logic [15:0] c_run   = 16'd0;
    logic        c_lvl   = 1'b0;
    logic [1:0]  c_pat   = 2'd0;

    logic [7:0]  tx_byte;
    logic [15:0] lane_byte;
    logic        tx_lane;
    logic        tx_sop;
    logic        tx_eop;
    logic        tx_payload;

    always #5 clk = ~clk;

    burst_pattern_gen i_burst_pattern_gen (
        .clk             (clk),
        .rst             (rst),
        .cfg_guard_bytes (c_guard),
        .cfg_pre_bytes   (c_pre),
        .cfg_pay_bytes   ({c_pay1, c_pay0}),
        .cfg_run_bytes   (c_run),
        .cfg_run_level   (c_lvl),
        .cfg_pattern     (c_pat),
        .tx_byte         (tx_byte),
        .lane_byte       (lane_byte),
        .tx_lane         (tx_lane),
        .tx_sop          (tx_sop),
        .tx_eop          (tx_eop),
        .tx_payload      (tx_payload)
    );

    typedef struct {
        int guard; int pre; int pay0; int pay1; int run;
        bit lvl; int pat; bit rst;
    } cfg_s;

    typedef struct {
        logic [7:0] b;
        bit sop; bit eop; bit pay;
        int lane; int req; int len;
    } exp_s;

    exp_s        q[$];
    cfg_s        h1, h2;
    logic [30:0] m_prbs;
    int          m_pat;
    int          m_lane;
    bit          m_first;
    int          obs_len;
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 0;

    function automatic cfg_s cur_cfg();
        cfg_s c;
        c.guard = c_guard; c.pre = c_pre; c.pay0 = c_pay0; c.pay1 = c_pay1;
        c.run = c_run; c.lvl = c_lvl; c.pat = c_pat; c.rst = rst;
        return c;
    endfunction

    function automatic string rq(int r);
        case (r)
            2:  return "R2";
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // serial model of the polynomials in R6, first bit into the MSB
    function automatic logic [7:0] model_prbs_byte();
        logic [7:0] b = '0;
        logic nb;
        for (int i = 0; i < 8; i++) begin
            case (m_pat)
                0:       nb = m_prbs[6]  ^ m_prbs[5];
                1:       nb = m_prbs[22] ^ m_prbs[17];
                default: nb = m_prbs[30] ^ m_prbs[27];
            endcase
            m_prbs = {m_prbs[29:0], nb};
            b      = {b[6:0], nb};
        end
        return b;
    endfunction

    task automatic push(logic [7:0] b, bit sop, bit pay, int req);
        exp_s e;
        e.b = b; e.sop = sop; e.eop = 0; e.pay = pay;
        e.lane = m_lane; e.req = req; e.len = 0;
        q.push_back(e);
    endtask

    // whole expected burst from the captured settings (R11)
    task automatic build(cfg_s c);
        int g, plen, first_tag, total;
        if (m_first || c.pat != m_pat) begin
            m_prbs    = '1;
            first_tag = m_first ? 6 : 12;   // R6 seed after reset, R12 restart
        end else begin
            first_tag = 7;                  // R7 continuation
        end
        m_pat   = c.pat;
        m_first = 0;
        g    = (c.guard == 0) ? 1 : c.guard;
        plen = (m_lane == 1) ? c.pay1 : c.pay0;
        for (int i = 0; i < g; i++) push(8'h00, i == 0, 0, 2);
        for (int i = 0; i < c.pre; i++) push(8'hAA, 0, 0, 3);
        push(8'hAB, 0, 0, 4);
        push(8'h59, 0, 0, 4);
        push(8'h83, 0, 0, 4);
        for (int i = 0; i < plen; i++) push(model_prbs_byte(), 0, 1, (i == 0) ? first_tag : 5);
        for (int i = 0; i < c.run; i++) push({8{c.lvl}}, 0, 0, 8);
        total = q.size();
        q[total-1].eop = 1;
        q[total-1].len = g + c.pre + 3 + plen + c.run;
        m_lane ^= 1;
    endtask

    // one falling edge: compare against the model, outputs come from the last rising edge
    task automatic step();
        exp_s e;
        logic [15:0] lane_exp;
        @(negedge clk);
        h2 = h1;
        h1 = cur_cfg();
        if (h1.rst) begin
            chk("R1", "tx_byte in reset", tx_byte, 0);
            chk("R1", "lane_byte in reset", lane_byte, 0);
            chk("R1", "strobes in reset", {tx_sop, tx_eop, tx_payload, tx_lane}, 0);
            q.delete();
            m_lane  = 0;
            m_first = 1;
            return;
        end
        if (q.size() == 0) build(h2);
        e = q.pop_front();
        obs_len = tx_sop ? 1 : obs_len + 1;
        chk(rq(e.req), "tx_byte", tx_byte, e.b);
        lane_exp = (e.lane == 1) ? {e.b, 8'h00} : {8'h00, e.b};
        chk("R9", "lane_byte", lane_byte, lane_exp);
        chk("R9", "tx_lane", tx_lane, e.lane);
        chk("R2", "tx_sop", tx_sop, e.sop);
        chk("R10", "tx_eop", tx_eop, e.eop);
        chk("R5", "tx_payload", tx_payload, e.pay);
        if (e.eop) chk("R11", "burst length", obs_len, e.len);
    endtask

    task automatic run_cycles(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic random_tweak();
        case ($urandom_range(6))
            0: c_guard = 8'($urandom_range(6));
            1: c_pre   = 8'($urandom_range(7));
            2: c_pay0  = 16'($urandom_range(40));
            3: c_pay1  = 16'($urandom_range(40));
            4: c_run   = 16'($urandom_range(10));
            5: c_lvl   = 1'($urandom_range(1));
            default: c_pat = 2'($urandom_range(3));
        endcase
    endtask

    initial begin
        void'($urandom(32'd20240611));
        h1 = cur_cfg();
        h2 = h1;
        // R1: reset holds everything at zero
        run_cycles(3);
        rst = 1'b0;
        // default burst shape: 4 guard, 5 training, sync, payloads, PRBS-7
        run_cycles(160);
        // R3/R8: no training field, empty lane-0 payload, run of ones, guard of zero clamps to one (R2)
        c_guard = 8'd0; c_pre = 8'd0; c_pay0 = 16'd0; c_run = 16'd6; c_lvl = 1'b1;
        run_cycles(120);
        // R12: switch to PRBS-23, then PRBS-31; R7 continuation while unchanged
        c_pat = 2'd1; c_pay0 = 16'd9; c_run = 16'd0;
        run_cycles(150);
        c_pat = 2'd2; c_lvl = 1'b0; c_run = 16'd3;
        run_cycles(150);
        // minimal burst: guard + sync only (R4, R10)
        c_guard = 8'd1; c_pre = 8'd0; c_pay0 = 16'd0; c_pay1 = 16'd0; c_run = 16'd0;
        run_cycles(40);
        // R11: settings rewritten at arbitrary bytes inside bursts
        c_pay0 = 16'd16; c_pay1 = 16'd7; c_pre = 8'd3; c_guard = 8'd2;
        for (int i = 0; i < 3000; i++) begin
            step();
            if ($urandom_range(15) == 0) random_tweak();
        end
        // reset in the middle of a burst, then resume (R1, R6)
        rst = 1'b1;
        run_cycles(2);
        rst = 1'b0;
        for (int i = 0; i < 400; i++) begin
            step();
            if ($urandom_range(15) == 0) random_tweak();
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(100000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule